// File: doc/BRIEF.md
# Packetized SPI Master with Pause

This block is an SPI master engine that shifts a transfer out as a number of packets of the same length. Software writes a configuration word that holds the packet length and the packet count, fills a transmit FIFO with 32-bit words, then writes a command word to start. The engine frames the transfer with chip select, drives the serial clock in mode 0 (clock idles low, data sampled on the rising edge) and loops the received bytes back into a receive FIFO as whole words. Timing is fixed by parameters: a half-period of the serial clock and the chip-select setup and hold times, all counted in system clocks.

A pause mode lets several transfers share one chip-select frame. With pause enabled, the engine stops after the last byte and leaves chip select asserted. Software loads more data and issues a resume command, which continues shifting with no new setup time. A command to reset the engine returns it to idle and releases chip select. Each transfer that ends raises a flag. The status word tells whether it ended idle or paused, and the interrupt output follows the enable bit for that kind of ending.

Register access uses a single-cycle port with word addresses: 0 configuration, 1 command, 2 transmit data, 3 receive data, 4 status.

Top module: `spi_pkt_master`

## Requirements
- R1: After reset, chip select is high, the serial clock and data out are low, the interrupt is low and the status word reads 0.
- R2: A transfer sends (L+1)*(M+1) bytes, eight rising serial-clock edges per byte, where L is configuration bits 25:16 and M is bits 15:8. The serial clock stays low while chip select is high.
- R3: A word written to address 2 joins the transmit FIFO. Its bytes go out least significant byte first, from bits 7:0 upward. If the FIFO is empty, the byte sent is zero.
- R4: Command bit 12 set makes each transmitted byte go out most significant bit first. Clear, it goes out least significant bit first.
- R5: Command bit 13 selects the bit order of received bytes in the same way, independently of bit 12.
- R6: Received bytes are packed least significant byte first into words that are pushed to the receive FIFO. The last word of a transfer is padded with zero bytes, so the word count is rounded up. A read at address 3 pops one word, and it returns 0 when the FIFO is empty.
- R7: When pause is off (command bit 4 clear), chip select returns high after the last byte. Status then reads bit0=1 and bit1=0, and the interrupt rises only if command bit 16 is set.
- R8: When command bit 4 is set, chip select stays low after the last byte and status reads bit1=1 and bit0=1. The interrupt rises if command bit 17 is set. Command bit 1 (resume) then sends the next transfer without chip select going high.
- R9: A read of the status word clears status bit0 and the interrupt.
- R10: Command bit 0 (start) has no effect while paused, and command bit 1 (resume) has no effect while idle.
- R11: Command bit 2 returns the engine to idle, raises chip select, empties both FIFOs and clears the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data, clears the status flag) |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| irq | output | 1 | Interrupt: a finished or paused transfer with its enable set |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The hardest state to reach is a resumed transfer inside one chip-select frame. The stimulus has to finish a paused transfer, show that a start command sent there does nothing, and then resume. The bench gets there by enabling pause, loading two words and starting a four-byte transfer. It then issues a stray start command, and finally a resume. It counts chip-select rising edges and serial-clock edges across the whole sequence, and it checks the second word's bits. The bench ties data out back to data in, so a mismatch between the two bit-order settings shows up as bit-reversed receive bytes.

// File: rtl/spi_pkt_master.sv
module spi_pkt_master #(
  parameter int FIFO_WORDS = 8,
  parameter int SCK_HALF   = 2,
  parameter int CS_SETUP   = 2,
  parameter int CS_HOLD    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam int PW = (FIFO_WORDS > 1) ? $clog2(FIFO_WORDS) : 1;
  localparam int CW = PW + 1;
  localparam int TW = $clog2(SCK_HALF + CS_SETUP + CS_HOLD + 1);
  localparam logic [2:0] A_CFG = 3'd0, A_CMD = 3'd1, A_TXD = 3'd2, A_RXD = 3'd3, A_STAT = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_PAUSE} eng_t;

  eng_t        state;
  logic [9:0]  len_m1;
  logic [7:0]  loop_m1;
  logic        pause_en, tx_msb, rx_msb, fin_ie, pse_ie;
  logic        flag, paused_end;

  logic [31:0] tx_mem [FIFO_WORDS];
  logic [31:0] rx_mem [FIFO_WORDS];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic [TW-1:0] tmr;
  logic        sclk_r;
  logic [2:0]  bit_idx;
  logic [18:0] byte_cnt, tot_r, tot_next;
  logic [7:0]  rx_byte;
  logic [31:0] rx_acc;

  logic eng_idle, eng_paused;
  assign eng_idle   = (state == S_IDLE);
  assign eng_paused = (state == S_PAUSE);

  wire cmd_wr  = reg_wr && reg_addr == A_CMD;
  wire do_srst = cmd_wr && reg_wdata[2];
  wire do_act  = cmd_wr && reg_wdata[0] && !reg_wdata[2] && state == S_IDLE;
  wire do_res  = cmd_wr && reg_wdata[1] && !reg_wdata[2] && state == S_PAUSE;
  wire stat_rd = reg_rd && reg_addr == A_STAT;

  wire [1:0]  lane    = byte_cnt[1:0];
  wire [31:0] tx_head = tx_mem[tx_rp];
  wire [7:0]  tx_byte = (tx_cnt != '0) ? tx_head[{lane, 3'b000} +: 8] : 8'h00;
  wire        tx_bit  = tx_msb ? tx_byte[~bit_idx] : tx_byte[bit_idx];

  wire tick     = (tmr == TW'(SCK_HALF - 1));
  wire bit_end  = (state == S_SHIFT) && tick && sclk_r;
  wire byte_end = bit_end && (bit_idx == 3'd7);
  wire last     = (byte_cnt + 19'd1 == tot_r);
  wire word_end = byte_end && (lane == 2'd3 || last);
  wire [31:0] rx_word = rx_acc | (32'(rx_byte) << {lane, 3'b000});

  wire push_tx = reg_wr && reg_addr == A_TXD && tx_cnt != CW'(FIFO_WORDS);
  wire pop_tx  = word_end && tx_cnt != '0;
  wire push_rx = word_end && rx_cnt != CW'(FIFO_WORDS);
  wire pop_rx  = reg_rd && reg_addr == A_RXD && rx_cnt != '0;

  assign tot_next = (19'(len_m1) + 19'd1) * (19'(loop_m1) + 19'd1);

  assign spi_sclk = sclk_r;
  assign spi_cs_n = (state == S_IDLE);
  assign spi_mosi = (state == S_SHIFT) && tx_bit;
  assign irq      = flag && (paused_end ? pse_ie : fin_ie);

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {6'b0, len_m1, loop_m1, 8'b0};
      A_CMD:   reg_rdata = {14'b0, pse_ie, fin_ie, 2'b0, rx_msb, tx_msb, 7'b0, pause_en, 4'b0};
      A_RXD:   reg_rdata = (rx_cnt != '0) ? rx_mem[rx_rp] : 32'h0;
      A_STAT:  reg_rdata = {30'b0, paused_end, flag};
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_m1 <= '0; loop_m1 <= '0;
      pause_en <= 1'b0; tx_msb <= 1'b0; rx_msb <= 1'b0; fin_ie <= 1'b0; pse_ie <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CFG) begin
        len_m1  <= reg_wdata[25:16];
        loop_m1 <= reg_wdata[15:8];
      end
      if (cmd_wr) begin
        pause_en <= reg_wdata[4];
        tx_msb   <= reg_wdata[12];
        rx_msb   <= reg_wdata[13];
        fin_ie   <= reg_wdata[16];
        pse_ie   <= reg_wdata[17];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_tx) tx_mem[tx_wp] <= reg_wdata;
    if (push_rx) rx_mem[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (do_srst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (push_tx) tx_wp <= (tx_wp == PW'(FIFO_WORDS - 1)) ? '0 : tx_wp + 1'b1;
      if (pop_tx)  tx_rp <= (tx_rp == PW'(FIFO_WORDS - 1)) ? '0 : tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(push_tx) - CW'(pop_tx);
      if (push_rx) rx_wp <= (rx_wp == PW'(FIFO_WORDS - 1)) ? '0 : rx_wp + 1'b1;
      if (pop_rx)  rx_rp <= (rx_rp == PW'(FIFO_WORDS - 1)) ? '0 : rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(push_rx) - CW'(pop_rx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; tmr <= '0; sclk_r <= 1'b0; bit_idx <= '0;
      byte_cnt <= '0; tot_r <= 19'd1; rx_byte <= '0; rx_acc <= '0;
      flag <= 1'b0; paused_end <= 1'b0;
    end else if (do_srst) begin
      state <= S_IDLE; tmr <= '0; sclk_r <= 1'b0; bit_idx <= '0;
      byte_cnt <= '0; rx_acc <= '0;
      flag <= 1'b0; paused_end <= 1'b0;
    end else begin
      if (stat_rd) flag <= 1'b0;
      case (state)
        S_IDLE: if (do_act) begin
          state <= S_SETUP; tmr <= '0; bit_idx <= '0;
          byte_cnt <= '0; rx_acc <= '0; tot_r <= tot_next;
        end
        S_SETUP: if (tmr == TW'(CS_SETUP - 1)) begin
          state <= S_SHIFT; tmr <= '0;
        end else tmr <= tmr + 1'b1;
        S_SHIFT: if (tick) begin
          tmr <= '0;
          if (!sclk_r) begin
            sclk_r <= 1'b1;
            rx_byte[rx_msb ? ~bit_idx : bit_idx] <= spi_miso;
          end else begin
            sclk_r  <= 1'b0;
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) begin
              byte_cnt <= byte_cnt + 19'd1;
              rx_acc   <= word_end ? 32'h0 : rx_word;
              if (last) begin
                if (pause_en) begin
                  state <= S_PAUSE; flag <= 1'b1; paused_end <= 1'b1;
                end else state <= S_HOLD;
              end
            end
          end
        end else tmr <= tmr + 1'b1;
        S_HOLD: if (tmr == TW'(CS_HOLD - 1)) begin
          state <= S_IDLE; tmr <= '0; flag <= 1'b1; paused_end <= 1'b0;
        end else tmr <= tmr + 1'b1;
        S_PAUSE: if (do_res) begin
          state <= S_SHIFT; tmr <= '0; bit_idx <= '0;
          byte_cnt <= '0; rx_acc <= '0; tot_r <= tot_next;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_pkt_master_chk.sv
module spi_pkt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        irq,
  input logic        spi_sclk,
  input logic        spi_cs_n,
  input logic        spi_mosi,
  input logic        eng_idle,
  input logic        eng_paused
);

  wire cmd_wr = reg_wr && reg_addr == 3'd1;

  AST_SCLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R2

  AST_MOSI_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_mosi); // R3

  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 3'd4 && !reg_wr && (eng_idle || eng_paused) |=> !irq); // R9

  AST_START_IGNORED_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_paused && cmd_wr && reg_wdata[0] && !reg_wdata[1] && !reg_wdata[2]
      |=> eng_paused && !spi_cs_n); // R10

  AST_RESUME_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle && cmd_wr && reg_wdata[1] && !reg_wdata[0] && !reg_wdata[2]
      |=> eng_idle && spi_cs_n); // R10

  AST_SRST_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && reg_wdata[2] |=> spi_cs_n && !irq); // R11

endmodule

bind spi_pkt_master spi_pkt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq),
  .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
  .eng_idle(eng_idle), .eng_paused(eng_paused)
);

// File: tb/tb_spi_pkt_master.sv
module tb_spi_pkt_master;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  assign spi_miso = spi_mosi;
  always #5 clk = ~clk;

  spi_pkt_master dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int nchk = 0, nfail = 0, ncap = 0, cs_rises = 0, cs_falls = 0;
  bit finished = 1'b0;
  logic [255:0] capbits;

  always @(posedge spi_sclk) begin
    if (ncap < 256) capbits[ncap] = spi_mosi;
    ncap = ncap + 1;
  end
  always @(posedge spi_cs_n) cs_rises = cs_rises + 1;
  always @(negedge spi_cs_n) cs_falls = cs_falls + 1;

  // fields: len_m1[67:58] loop_m1[57:50] tx_msb[49] rx_msb[48] bytes[47:32] seed[31:0]
  localparam logic [67:0] VEC [5] = '{
    {10'd3, 8'd0, 1'b1, 1'b1, 16'd4,  32'hA5C30F81},
    {10'd4, 8'd1, 1'b0, 1'b0, 16'd10, 32'h12345678},
    {10'd0, 8'd6, 1'b1, 1'b0, 16'd7,  32'hDEADBEEF},
    {10'd7, 8'd3, 1'b0, 1'b1, 16'd32, 32'h0BADF00D},
    {10'd2, 8'd0, 1'b1, 1'b1, 16'd3,  32'hC001D00D}
  };

  function automatic logic [31:0] wordval(logic [31:0] seed, int j);
    return seed + 32'(j) * 32'h9E3779B9;
  endfunction

  function automatic logic [7:0] txbyte(logic [31:0] seed, int idx);
    logic [31:0] w;
    w = wordval(seed, idx / 4);
    return w[(idx % 4) * 8 +: 8];
  endfunction

  function automatic logic exp_bit(logic [31:0] seed, int k, logic msb);
    logic [7:0] b;
    b = txbyte(seed, k / 8);
    return msb ? b[7 - (k % 8)] : b[k % 8];
  endfunction

  function automatic logic [7:0] rev8(logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7 - i];
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_irq(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1'b1; break; end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    summary();
  end

  initial begin
    logic [31:0] d, mode, exp;
    bit ok;
    int bad, snap, rises;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(spi_cs_n && !spi_sclk && !spi_mosi && !irq, "R1", "pins after reset",
          {29'b0, spi_cs_n, spi_sclk, irq}, 32'h4);
    rst_n = 1'b1;
    rd(3'd4, d);
    check(d == 32'h0, "R1", "status after reset", d, 32'h0);

    for (int v = 0; v < 5; v++) begin
      logic [9:0] lm; logic [7:0] pm; logic txm, rxm; int nb; logic [31:0] sd;
      lm = VEC[v][67:58]; pm = VEC[v][57:50]; txm = VEC[v][49]; rxm = VEC[v][48];
      nb = int'(VEC[v][47:32]); sd = VEC[v][31:0];
      mode = (32'h1 << 16) | (32'(txm) << 12) | (32'(rxm) << 13);
      wr(3'd1, mode);
      wr(3'd0, (32'(lm) << 16) | (32'(pm) << 8));
      for (int j = 0; j < (nb + 3) / 4; j++) wr(3'd2, wordval(sd, j));
      ncap = 0;
      wr(3'd1, mode | 32'h1);
      wait_irq(ok);
      check(ok, "R7", "finish interrupt", 32'(ok), 32'h1);
      check(ncap == 8 * nb, "R2", "sclk rising edges", 32'(ncap), 32'(8 * nb));
      bad = 0;
      for (int k = 0; k < 8 * nb; k++) if (capbits[k] !== exp_bit(sd, k, txm)) bad++;
      check(bad == 0, "R3 R4", "mismatched mosi bits", 32'(bad), 32'h0);
      check(spi_cs_n, "R7", "cs released at finish", 32'(spi_cs_n), 32'h1);
      rd(3'd4, d);
      check(d == 32'h1, "R7", "status finish", d, 32'h1);
      @(negedge clk);
      check(!irq, "R9", "irq after status read", 32'(irq), 32'h0);
      for (int j = 0; j < (nb + 3) / 4; j++) begin
        exp = 32'h0;
        for (int l = 0; l < 4; l++)
          if (j * 4 + l < nb)
            exp[l * 8 +: 8] = (txm == rxm) ? txbyte(sd, j * 4 + l) : rev8(txbyte(sd, j * 4 + l));
        rd(3'd3, d);
        check(d == exp, "R5 R6", "rx word", d, exp);
      end
      rd(3'd3, d);
      check(d == 32'h0, "R6", "rx empty after drain", d, 32'h0);
    end

    // R7: finish without interrupt enable
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h0000005A);
    wr(3'd1, 32'h1);
    bad = 0;
    for (int i = 0; i < 150; i++) begin @(negedge clk); if (irq) bad++; end
    check(bad == 0, "R7", "irq with finish disabled", 32'(bad), 32'h0);
    rd(3'd4, d);
    check(d == 32'h1, "R7", "status with finish disabled", d, 32'h1);
    rd(3'd3, d);

    // R8: pause, stray start, resume in one frame
    mode = (32'h1 << 4) | (32'h1 << 17) | (32'h1 << 12) | (32'h1 << 13);
    wr(3'd1, mode);
    wr(3'd0, 32'd3 << 16);
    wr(3'd2, wordval(32'h5A5A1234, 0));
    wr(3'd2, wordval(32'h5A5A1234, 1));
    ncap = 0;
    wr(3'd1, mode | 32'h1);
    wait_irq(ok);
    check(ok && !spi_cs_n, "R8", "pause irq with cs held", {30'b0, ok, spi_cs_n}, 32'h2);
    rd(3'd4, d);
    check(d == 32'h3, "R8", "status paused", d, 32'h3);
    @(negedge clk);
    check(!irq, "R9", "irq cleared in pause", 32'(irq), 32'h0);
    wr(3'd1, mode | 32'h1);
    repeat (100) @(negedge clk);
    check(ncap == 32 && !spi_cs_n, "R10", "start while paused", 32'(ncap), 32'd32);
    rd(3'd4, d);
    check(d == 32'h2, "R10", "status after stray start", d, 32'h2);
    rises = cs_rises;
    wr(3'd1, mode | 32'h2);
    wait_irq(ok);
    check(ok && ncap == 64, "R8", "resume bit count", 32'(ncap), 32'd64);
    check(cs_rises == rises && !spi_cs_n, "R8", "cs held across resume", 32'(cs_rises - rises), 32'h0);
    bad = 0;
    for (int k = 32; k < 64; k++) if (capbits[k] !== exp_bit(32'h5A5A1234, k, 1'b1)) bad++;
    check(bad == 0, "R8", "resumed mosi bits", 32'(bad), 32'h0);
    rd(3'd4, d);
    check(d == 32'h3, "R8", "status paused again", d, 32'h3);

    // R11: reset command leaves pause
    wr(3'd1, 32'h4);
    check(spi_cs_n && !irq, "R11", "cs after reset command", 32'(spi_cs_n), 32'h1);
    rd(3'd4, d);
    check(d == 32'h0, "R11", "status after reset command", d, 32'h0);
    rd(3'd3, d);
    check(d == 32'h0, "R11", "rx fifo emptied", d, 32'h0);

    // R10: resume while idle
    snap = ncap; rises = cs_falls;
    wr(3'd1, 32'h2);
    repeat (100) @(negedge clk);
    check(ncap == snap && cs_falls == rises && spi_cs_n, "R10", "resume while idle",
          32'(ncap - snap), 32'h0);

    // R11: reset command empties tx fifo; R3 empty fifo sends zero
    wr(3'd2, 32'hFFFFFFFF);
    wr(3'd1, 32'h4);
    wr(3'd0, 32'h0);
    ncap = 0;
    wr(3'd1, (32'h1 << 16) | 32'h1);
    wait_irq(ok);
    check(ok && ncap == 8 && capbits[7:0] == 8'h00, "R11", "tx fifo emptied",
          {24'b0, capbits[7:0]}, 32'h0);
    rd(3'd4, d);

    summary();
  end

endmodule